// File: doc/BRIEF.md
# Register Rename and Allocation Unit

This block gives each incoming micro-op physical register tags in place of its architectural register numbers. An alias table records which physical register holds the newest value of each architectural register. For every accepted micro-op the unit reads the physical tags of both sources, takes a free physical register for the destination, and points the alias table at that register, so that later readers find the newest instance. The displaced tag goes out with the micro-op. Retirement later hands that tag back on the release port, and the tag rejoins the free pool.

Both stream interfaces use valid/ready. A transfer happens on a clock edge where valid and ready are both high. The input side is not ready while the output register holds a micro-op that the consumer is not taking. It is also not ready while the free pool is empty and the offered micro-op writes a destination. A micro-op without a destination can still pass when the pool is empty. The output holds its payload until it is taken. At most one micro-op is renamed per cycle. Each architectural register also keeps an instance counter, and every new version of that register carries the counter value.

Top module: `rename_alloc_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Architectural register i maps to physical tag i, and tags NUM_ARCH..NUM_PHYS-1 are free. A destination always gets the lowest-numbered free physical tag.
- R2: `out_src_a_tag` and `out_src_b_tag` equal the physical tag most recently assigned to `in_src_a` and `in_src_b`.
- R3: A micro-op whose source and destination name the same architectural register reads the mapping as it stood before its own destination update.
- R4: `out_old_tag` is the mapping that the destination held before this micro-op, and it differs from `out_dst_tag`.
- R5: `out_seq` is the count, modulo 2^SEQ_W, of destination-writing micro-ops renamed to that architectural register since reset, including this one.
- R6: A micro-op with `in_dst_en`=0 uses no free register and leaves the alias table unchanged. It outputs `out_dst_en`=0, with `out_dst_tag`, `out_old_tag` and `out_seq` all 0.
- R7: `in_ready` = (output empty or `out_ready`) and (pool not empty or `in_dst_en`=0). The pool state used here is the state before the current cycle's release.
- R8: A tag on `rel_valid`/`rel_tag` becomes free from the next cycle. A release and an allocation in the same cycle are both honoured. The pool never holds more than NUM_PHYS-NUM_ARCH free tags.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output payload and `out_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op can be taken this cycle |
| in_src_a | input | ARCH_W | First source architectural register |
| in_src_b | input | ARCH_W | Second source architectural register |
| in_dst | input | ARCH_W | Destination architectural register |
| in_dst_en | input | 1 | Micro-op writes a destination |
| out_valid | output | 1 | Renamed micro-op present |
| out_ready | input | 1 | Consumer takes the renamed micro-op |
| out_src_a_tag | output | TAG_W | Physical tag of first source |
| out_src_b_tag | output | TAG_W | Physical tag of second source |
| out_dst_tag | output | TAG_W | Newly allocated destination tag |
| out_old_tag | output | TAG_W | Previous destination mapping |
| out_dst_en | output | 1 | Destination fields are meaningful |
| out_seq | output | SEQ_W | Instance number of the new version |
| rel_valid | input | 1 | Retirement frees a tag |
| rel_tag | input | TAG_W | Tag to return to the pool |

## Verification
The bench drains the whole pool and offers a destination-writing micro-op while the pool is empty. A unit that checked the pool wrongly would hand out a tag that is already in use, or would fail to stall. It releases a tag in the same cycle as a stalled request and in the same cycle as a real allocation. A pool that dropped one of the two updates would lose the tag or hand it out twice. Directed micro-ops read and write the same register, which catches a unit that forwards its own new tag to the source. Micro-ops without a destination are issued, including while the pool is empty. A unit that consumed a register for them, or stalled them, shows up as a wrong tag or a wrong ready. Random back-pressure on the output catches a payload that changes while it is held.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int DEF_NUM_ARCH = 8;
  localparam int DEF_NUM_PHYS = 128;
  localparam int DEF_SEQ_W    = 6;
endpackage

// File: rtl/rename_free_pool.sv
module rename_free_pool #(
  parameter int NUM_PHYS = 128,
  parameter int NUM_ARCH = 8,
  localparam int TAG_W = $clog2(NUM_PHYS),
  localparam int CNT_W = $clog2(NUM_PHYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [TAG_W-1:0] pick_tag,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  input  logic             give,
  input  logic [TAG_W-1:0] give_tag
);
  logic [NUM_PHYS-1:0] avail_q, avail_d;
  logic [CNT_W-1:0]    cnt_q;

  // lowest-numbered free tag
  always_comb begin
    pick_tag = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (avail_q[i]) pick_tag = TAG_W'(i);
    end
  end

  always_comb begin
    avail_d = avail_q;
    if (take) avail_d[pick_tag] = 1'b0;
    if (give) avail_d[give_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) avail_q[i] <= (i >= NUM_ARCH);
      cnt_q <= CNT_W'(NUM_PHYS - NUM_ARCH);
    end else begin
      avail_q <= avail_d;
      cnt_q   <= cnt_q + CNT_W'(give) - CNT_W'(take);
    end
  end

  assign empty = (cnt_q == '0);
  assign count = cnt_q;
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int NUM_ARCH = 8,
  parameter int TAG_W    = 7,
  parameter int SEQ_W    = 6,
  localparam int ARCH_W = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] rd_a,
  input  logic [ARCH_W-1:0] rd_b,
  input  logic [ARCH_W-1:0] rd_d,
  output logic [TAG_W-1:0]  tag_a,
  output logic [TAG_W-1:0]  tag_b,
  output logic [TAG_W-1:0]  tag_d,
  output logic [SEQ_W-1:0]  seq_d,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_arch,
  input  logic [TAG_W-1:0]  wr_tag
);
  logic [TAG_W-1:0] map_w [NUM_ARCH];
  logic [SEQ_W-1:0] seq_w [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    logic [TAG_W-1:0] ent_tag;
    logic [SEQ_W-1:0] ent_seq;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_tag <= TAG_W'(g);
        ent_seq <= '0;
      end else if (wr_en && wr_arch == ARCH_W'(g)) begin
        ent_tag <= wr_tag;
        ent_seq <= ent_seq + 1'b1;
      end
    end
    assign map_w[g] = ent_tag;
    assign seq_w[g] = ent_seq;
  end

  // reads see the table before this cycle's write
  assign tag_a = map_w[rd_a];
  assign tag_b = map_w[rd_b];
  assign tag_d = map_w[rd_d];
  assign seq_d = seq_w[rd_d];
endmodule

// File: rtl/rename_out_stage.sv
module rename_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_data,
  output logic         can_load,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q_data
);
  assign can_load = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (ld_valid && can_load) begin
      q_valid <= 1'b1;
      q_data  <= ld_data;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rename_alloc_unit.sv
module rename_alloc_unit
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = DEF_NUM_ARCH,
  parameter int NUM_PHYS = DEF_NUM_PHYS,
  parameter int SEQ_W    = DEF_SEQ_W,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int TAG_W  = $clog2(NUM_PHYS),
  localparam int CNT_W  = $clog2(NUM_PHYS + 1),
  localparam int PAY_W  = 4 * TAG_W + 1 + SEQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ARCH_W-1:0] in_src_a,
  input  logic [ARCH_W-1:0] in_src_b,
  input  logic [ARCH_W-1:0] in_dst,
  input  logic              in_dst_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_src_a_tag,
  output logic [TAG_W-1:0]  out_src_b_tag,
  output logic [TAG_W-1:0]  out_dst_tag,
  output logic [TAG_W-1:0]  out_old_tag,
  output logic              out_dst_en,
  output logic [SEQ_W-1:0]  out_seq,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag
);
  logic             accept, take, pool_empty, slot_free;
  logic [TAG_W-1:0] new_tag, tag_a, tag_b, tag_d;
  logic [SEQ_W-1:0] seq_d;
  logic [CNT_W-1:0] pool_cnt;
  logic [PAY_W-1:0] pay_d, pay_q;

  assign in_ready = slot_free && (!pool_empty || !in_dst_en);
  assign accept   = in_valid && in_ready;
  assign take     = accept && in_dst_en;

  rename_free_pool #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_pool (
    .clk(clk), .rst_n(rst_n), .take(take), .pick_tag(new_tag),
    .empty(pool_empty), .count(pool_cnt), .give(rel_valid), .give_tag(rel_tag)
  );

  rename_alias_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_rat (
    .clk(clk), .rst_n(rst_n), .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
    .tag_a(tag_a), .tag_b(tag_b), .tag_d(tag_d), .seq_d(seq_d),
    .wr_en(take), .wr_arch(in_dst), .wr_tag(new_tag)
  );

  always_comb begin
    if (in_dst_en)
      pay_d = {tag_a, tag_b, new_tag, tag_d, 1'b1, seq_d + 1'b1};
    else
      pay_d = {tag_a, tag_b, {TAG_W{1'b0}}, {TAG_W{1'b0}}, 1'b0, {SEQ_W{1'b0}}};
  end

  rename_out_stage #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ld_valid(in_valid && in_ready), .ld_data(pay_d),
    .can_load(slot_free), .q_valid(out_valid), .q_ready(out_ready), .q_data(pay_q)
  );

  assign {out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag, out_dst_en, out_seq} = pay_q;
endmodule

// File: rtl/rename_alloc_chk.sv
module rename_alloc_chk #(
  parameter int ARCH_W   = 3,
  parameter int TAG_W    = 7,
  parameter int SEQ_W    = 6,
  parameter int CNT_W    = 8,
  parameter int MAX_FREE = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ARCH_W-1:0] in_src_a,
  input logic [ARCH_W-1:0] in_dst,
  input logic              in_dst_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TAG_W-1:0]  out_src_a_tag,
  input logic [TAG_W-1:0]  out_src_b_tag,
  input logic [TAG_W-1:0]  out_dst_tag,
  input logic [TAG_W-1:0]  out_old_tag,
  input logic              out_dst_en,
  input logic [SEQ_W-1:0]  out_seq,
  input logic [CNT_W-1:0]  pool_cnt
);
  // R9
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src_a_tag) && $stable(out_src_b_tag)
      && $stable(out_dst_tag) && $stable(out_old_tag) && $stable(out_dst_en) && $stable(out_seq)));

  // R3
  self_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dst_en && in_src_a == in_dst) |=> (out_src_a_tag == out_old_tag));

  // R4
  fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dst_en) |=> (out_dst_en && out_dst_tag != out_old_tag));

  // R6
  no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_dst_en) |=> (!out_dst_en && out_dst_tag == '0 && out_old_tag == '0 && out_seq == '0));

  // R7
  no_alloc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dst_en) |-> (pool_cnt != '0));

  // R8
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_cnt <= CNT_W'(MAX_FREE));
endmodule

bind rename_alloc_unit rename_alloc_chk #(
  .ARCH_W(ARCH_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .MAX_FREE(NUM_PHYS - NUM_ARCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_src_a(in_src_a),
  .in_dst(in_dst), .in_dst_en(in_dst_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag),
  .out_old_tag(out_old_tag), .out_dst_en(out_dst_en), .out_seq(out_seq), .pool_cnt(pool_cnt)
);

// File: tb/test_rename_alloc_unit.sv
module test_rename_alloc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_dst_en = 1'b0, out_ready = 1'b0, rel_valid = 1'b0;
  logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [6:0] rel_tag = '0;
  logic in_ready, out_valid, out_dst_en;
  logic [6:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag;
  logic [5:0] out_seq;

  int checks = 0;
  int fails = 0;

  // reference model
  int m_map[8];
  int m_seq[8];
  bit m_free[128];
  int m_cnt;
  int pend[$];
  bit e_full;
  int e_sa, e_sb, e_dt, e_ot, e_de, e_sq;

  always #10 clk = ~clk;

  rename_alloc_unit i_rename_alloc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_src_a_tag(out_src_a_tag),
    .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag), .out_old_tag(out_old_tag),
    .out_dst_en(out_dst_en), .out_seq(out_seq), .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 128; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_map[i] = i; m_seq[i] = 0; end
    for (int i = 0; i < 128; i++) m_free[i] = (i >= 8);
    m_cnt = 120;
    e_full = 0;
    pend.delete();
  endtask

  task automatic step(input bit iv, input int sa, input int sb, input int d, input bit de,
                      input bit ordy, input bit rv, input int rt);
    bit exp_rdy;
    @(negedge clk);
    in_valid = iv; in_src_a = 3'(sa); in_src_b = 3'(sb); in_dst = 3'(d); in_dst_en = de;
    out_ready = ordy; rel_valid = rv; rel_tag = 7'(rt);
    #1;
    exp_rdy = (!e_full || ordy) && (m_cnt > 0 || !de);
    chk(out_valid === e_full, "R9 out_valid", int'(out_valid), int'(e_full));
    if (e_full && ordy) begin
      chk(out_src_a_tag == 7'(e_sa), "R2 src_a", int'(out_src_a_tag), e_sa);
      chk(out_src_b_tag == 7'(e_sb), "R2 src_b", int'(out_src_b_tag), e_sb);
      chk(out_dst_tag == 7'(e_dt), "R1 dst_tag", int'(out_dst_tag), e_dt);
      chk(out_old_tag == 7'(e_ot), "R4 old_tag", int'(out_old_tag), e_ot);
      chk(out_dst_en == 1'(e_de), "R6 dst_en", int'(out_dst_en), e_de);
      chk(out_seq == 6'(e_sq), "R5 seq", int'(out_seq), e_sq);
      e_full = 0;
    end
    if (iv) chk(in_ready === exp_rdy, "R7 in_ready", int'(in_ready), int'(exp_rdy));
    if (iv && in_ready) begin
      e_sa = m_map[sa]; e_sb = m_map[sb]; e_de = de;
      if (de) begin
        e_dt = lowest_free();
        e_ot = m_map[d];
        m_free[e_dt] = 0;
        m_cnt--;
        m_map[d] = e_dt;
        m_seq[d] = (m_seq[d] + 1) % 64;
        e_sq = m_seq[d];
        pend.push_back(e_ot);
      end else begin
        e_dt = 0; e_ot = 0; e_sq = 0;
      end
      e_full = 1;
    end
    if (rv) begin m_free[rt] = 1; m_cnt++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int x, y, z;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(in_ready === 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R3: read and write of the same register in one micro-op
    step(1, 1, 2, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_src_a_tag == 7'd1, "R3 self read", int'(out_src_a_tag), 1);
    chk(out_dst_tag == 7'd8, "R1 first alloc", int'(out_dst_tag), 8);
    chk(out_old_tag == 7'd1, "R4 first old", int'(out_old_tag), 1);
    chk(out_seq == 6'd1, "R5 first instance", int'(out_seq), 1);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // R6: no destination
    step(1, 3, 1, 5, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_dst_tag == 7'd0 && out_seq == 6'd0, "R6 no dest fields", int'(out_dst_tag), 0);
    chk(out_src_b_tag == 7'd8, "R2 newest instance", int'(out_src_b_tag), 8);
    step(1, 1, 1, 4, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_dst_tag == 7'd9, "R6 no register consumed", int'(out_dst_tag), 9);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // R7: drain the pool
    while (m_cnt > 0) step(1, $urandom % 8, $urandom % 8, $urandom % 8, 1, 1, 0, 0);
    step(1, 0, 0, 2, 1, 1, 0, 0);
    chk(in_ready === 1'b0, "R7 stall on empty", int'(in_ready), 0);
    step(1, 0, 1, 0, 0, 1, 0, 0);
    chk(in_ready === 1'b1, "R7 no-dest passes empty", int'(in_ready), 1);

    // R8: release during a stalled request
    x = pend.pop_front();
    step(1, 0, 0, 2, 1, 1, 1, x);
    chk(in_ready === 1'b0, "R8 release not yet visible", int'(in_ready), 0);
    step(1, 0, 0, 2, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_dst_tag == 7'(x), "R8 released tag reused", int'(out_dst_tag), x);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // R8: release and allocation in the same cycle
    y = pend.pop_front();
    z = pend.pop_front();
    step(0, 0, 0, 0, 0, 1, 1, y);
    step(1, 2, 3, 6, 1, 1, 1, z);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_dst_tag == 7'(y), "R8 alloc with release", int'(out_dst_tag), y);
    step(1, 6, 6, 7, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(out_dst_tag == 7'(z), "R8 same-cycle release kept", int'(out_dst_tag), z);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // random mix with back-pressure and retirement
    for (int n = 0; n < 4000; n++) begin
      bit rv;
      int rt;
      rv = 0; rt = 0;
      if (pend.size() > 0 && ($urandom % 100) < 45) begin
        int idx;
        idx = $urandom % pend.size();
        rt = pend[idx];
        pend.delete(idx);
        rv = 1;
      end
      step(($urandom % 100) < 80, $urandom % 8, $urandom % 8, $urandom % 8,
           ($urandom % 100) < 80, ($urandom % 100) < 70, rv, rt);
    end
    for (int n = 0; n < 3; n++) step(0, 0, 0, 0, 0, 1, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule